// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block owns the 8-bit status byte of a serial NOR flash command controller. A command decoder in front of it issues one-cycle strobes for write enable, write disable, status write (with its data byte) and the four kinds of array write: page program, sector erase, block erase and chip erase. The block decides whether each strobe is accepted, tracks whether an internal array write is in progress, and keeps the write-enable latch and the block-protect field up to date.

An internal write ends either when the `op_done` strobe arrives or, when the internal timer is enabled, after a fixed number of cycles chosen per kind of operation. The block presents the status byte for status reads, a flag telling the decoder whether array writes may start now, and the current protect level and lock bit for the region-protection logic.

Top module: `sflash_status_unit`

## Requirements
- R1: The status byte holds BUSY at bit 0, the write-enable latch at bit 1, the protect level at bits 4:2 (bit 2 least significant), the lock bit at bit 7, and bits 6:5 always read 0.
- R2: After reset, and on any reset even during an internal write, the status byte is 0x1C: not busy, latch clear, protect level 3'b111, lock clear.
- R3: When not busy, a write-enable strobe sets the latch on the next clock and a write-disable strobe clears it on the next clock.
- R4: A program or erase strobe while the latch is 0 is ignored: BUSY stays 0 and the status byte does not change.
- R5: An accepted program or erase sets BUSY on the next clock; with the timer enabled BUSY then lasts exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles for program, sector, block or chip erase.
- R6: The latch stays set while BUSY is 1 and clears on the same clock on which BUSY falls.
- R7: A status write with the latch at 1 and the lock at 0 loads the protect level from data bits 4:2 and the lock from data bit 7, ignores data bits 6:5, 1 and 0, and clears the latch.
- R8: A status write while the lock is 1 leaves the protect level unchanged, still loads the lock from data bit 7 and still clears the latch.
- R9: A status write while the latch is 0 is ignored.
- R10: While BUSY is 1, write enable, write disable, status write, program and erase strobes are all ignored.
- R11: `write_allowed_o` is 1 exactly when the latch is 1 and BUSY is 0; `bp_level_o` and `bp_lock_o` equal status bits 4:2 and 7.
- R12: An `op_done` strobe while BUSY is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_prog | input | 1 | Page program start strobe |
| cmd_sect_erase | input | 1 | Sector erase start strobe |
| cmd_blk_erase | input | 1 | Block erase start strobe |
| cmd_chip_erase | input | 1 | Chip erase start strobe |
| op_done | input | 1 | Completion strobe of the running internal write |
| status_o | output | 8 | Current status byte |
| busy_o | output | 1 | Internal write in progress |
| write_allowed_o | output | 1 | Array write may start now |
| bp_level_o | output | 3 | Current protect level |
| bp_lock_o | output | 1 | Protect level is locked |

## Verification
The assertions assume the decoder raises at most one command strobe per cycle and holds each for a single cycle, since the acceptance priority between simultaneous strobes is not part of the contract. The stimulus drives every command through one task that raises a single strobe for exactly one clock and drops it, and it issues `op_done` only as a lone strobe, both during and outside an internal write. With that, the latch, busy and protect-field properties can be stated per strobe without guarding against overlapping commands.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BP   = 2;
  localparam int BP_W     = 3;
  localparam int BIT_LOCK = 7;
  localparam logic [BP_W-1:0] BP_RESET = '1;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;
endpackage

// File: rtl/sfs_busy_ctrl.sv
module sfs_busy_ctrl
  import sfs_pkg::*;
#(
  parameter int USE_TIMER = 1,
  parameter int PROG_CYC  = 8,
  parameter int SECT_CYC  = 16,
  parameter int BLK_CYC   = 24,
  parameter int CHIP_CYC  = 40
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  op_kind_e kind_i,
  input  logic     done_i,
  output logic     busy_o,
  output logic     finish_o
);
  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic busy_q;
  logic tmr_hit;

  assign finish_o = busy_q & (done_i | tmr_hit);
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (start_i)  busy_q <= 1'b1;
    else if (finish_o) busy_q <= 1'b0;
  end

  generate
    if (USE_TIMER != 0) begin : g_timer
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] load_val;

      always_comb begin
        unique case (kind_i)
          OP_PROG: load_val = CNT_W'(PROG_CYC - 1);
          OP_SECT: load_val = CNT_W'(SECT_CYC - 1);
          OP_BLK:  load_val = CNT_W'(BLK_CYC - 1);
          default: load_val = CNT_W'(CHIP_CYC - 1);
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst)                              cnt_q <= '0;
        else if (start_i)                     cnt_q <= load_val;
        else if (busy_q && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
      end

      assign tmr_hit = (cnt_q == '0);

      // R5
      tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !finish_o) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
    end else begin : g_no_timer
      assign tmr_hit = 1'b0;
    end
  endgenerate

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_q);
endmodule

// File: rtl/sfs_wel.sv
module sfs_wel (
  input  logic clk,
  input  logic rst,
  input  logic wren_ok_i,
  input  logic wrdi_ok_i,
  input  logic wrsr_ok_i,
  input  logic finish_i,
  input  logic busy_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk) begin
    if (rst)                                   wel_q <= 1'b0;
    else if (finish_i || wrdi_ok_i || wrsr_ok_i) wel_q <= 1'b0;
    else if (wren_ok_i)                        wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R3
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wren_ok_i && !finish_i) |=> wel_q);

  // R6
  wel_clr_chk: assert property (@(posedge clk) disable iff (rst)
    finish_i |=> !wel_q);

  // R10
  wel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !finish_i) |=> $stable(wel_q));
endmodule

// File: rtl/sfs_bp_reg.sv
module sfs_bp_reg
  import sfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wrsr_ok_i,
  input  logic [BP_W-1:0] bp_d_i,
  input  logic            lock_d_i,
  input  logic            busy_i,
  output logic [BP_W-1:0] bp_o,
  output logic            lock_o
);
  logic [BP_W-1:0] bp_q;
  logic            lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q   <= BP_RESET;
      lock_q <= 1'b0;
    end else if (wrsr_ok_i) begin
      lock_q <= lock_d_i;
      if (!lock_q) bp_q <= bp_d_i;
    end
  end

  assign bp_o   = bp_q;
  assign lock_o = lock_q;

  // R8
  bp_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wrsr_ok_i && lock_q) |=> $stable(bp_q));

  // R10
  bp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(bp_q) && $stable(lock_q)));
endmodule

// File: rtl/sflash_status_unit.sv
module sflash_status_unit
  import sfs_pkg::*;
#(
  parameter int USE_TIMER = 1,
  parameter int PROG_CYC  = 8,
  parameter int SECT_CYC  = 16,
  parameter int BLK_CYC   = 24,
  parameter int CHIP_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              cmd_prog,
  input  logic              cmd_sect_erase,
  input  logic              cmd_blk_erase,
  input  logic              cmd_chip_erase,
  input  logic              op_done,
  output logic [STAT_W-1:0] status_o,
  output logic              busy_o,
  output logic              write_allowed_o,
  output logic [BP_W-1:0]   bp_level_o,
  output logic              bp_lock_o
);
  logic            busy, finish, wel, lock;
  logic [BP_W-1:0] bp;
  logic            idle, any_start, start_ok;
  logic            wren_ok, wrdi_ok, wrsr_ok;
  op_kind_e        kind;

  assign idle      = ~busy;
  assign any_start = cmd_prog | cmd_sect_erase | cmd_blk_erase | cmd_chip_erase;
  assign start_ok  = any_start & idle & wel;
  assign wren_ok   = cmd_wren & idle;
  assign wrdi_ok   = cmd_wrdi & idle;
  assign wrsr_ok   = cmd_wrsr & idle & wel;

  always_comb begin
    if (cmd_prog)            kind = OP_PROG;
    else if (cmd_sect_erase) kind = OP_SECT;
    else if (cmd_blk_erase)  kind = OP_BLK;
    else                     kind = OP_CHIP;
  end

  sfs_busy_ctrl #(
    .USE_TIMER (USE_TIMER),
    .PROG_CYC  (PROG_CYC),
    .SECT_CYC  (SECT_CYC),
    .BLK_CYC   (BLK_CYC),
    .CHIP_CYC  (CHIP_CYC)
  ) u_busy (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_ok),
    .kind_i   (kind),
    .done_i   (op_done),
    .busy_o   (busy),
    .finish_o (finish)
  );

  sfs_wel u_wel (
    .clk       (clk),
    .rst       (rst),
    .wren_ok_i (wren_ok),
    .wrdi_ok_i (wrdi_ok),
    .wrsr_ok_i (wrsr_ok),
    .finish_i  (finish),
    .busy_i    (busy),
    .wel_o     (wel)
  );

  sfs_bp_reg u_bp (
    .clk       (clk),
    .rst       (rst),
    .wrsr_ok_i (wrsr_ok),
    .bp_d_i    (wrsr_data[BIT_BP +: BP_W]),
    .lock_d_i  (wrsr_data[BIT_LOCK]),
    .busy_i    (busy),
    .bp_o      (bp),
    .lock_o    (lock)
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_BUSY] = busy;
    status_o[BIT_WEL]  = wel;
    status_o[BIT_BP +: BP_W] = bp;
    status_o[BIT_LOCK] = lock;
  end

  assign busy_o          = busy;
  assign write_allowed_o = wel & idle;
  assign bp_level_o      = bp;
  assign bp_lock_o       = lock;

  // R4
  no_wel_start_chk: assert property (@(posedge clk) disable iff (rst)
    (any_start && !busy_o && !status_o[BIT_WEL]) |=> !busy_o);

  // R12
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && !busy_o && !any_start) |=> !busy_o);
endmodule

// File: tb/sflash_status_unit_tb_top.sv
module sflash_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC = 8;
  localparam int SECT_CYC = 16;
  localparam int BLK_CYC  = 24;
  localparam int CHIP_CYC = 40;

  localparam logic [3:0] C_NONE = 4'd0, C_WREN = 4'd1, C_WRDI = 4'd2, C_WRSR = 4'd3,
                         C_PROG = 4'd4, C_SECT = 4'd5, C_BLK = 4'd6, C_CHIP = 4'd7,
                         C_DONE = 4'd8;

  // {cmd[31:28], data[27:20], extra wait[19:12], expected status[11:4], req[3:0]}
  localparam int NV = 37;
  localparam logic [31:0] VECS [0:NV-1] = '{
    {C_PROG, 8'h00, 8'd0,  8'h1C, 4'd4},   // R4 program without latch
    {C_CHIP, 8'h00, 8'd0,  8'h1C, 4'd4},   // R4 chip erase without latch
    {C_WRSR, 8'h00, 8'd0,  8'h1C, 4'd9},   // R9 status write without latch
    {C_WREN, 8'h00, 8'd0,  8'h1E, 4'd3},   // R3
    {C_WRDI, 8'h00, 8'd0,  8'h1C, 4'd3},   // R3
    {C_WREN, 8'h00, 8'd0,  8'h1E, 4'd3},
    {C_WRSR, 8'h63, 8'd0,  8'h00, 4'd7},   // R7 reserved, busy, latch bits ignored; R1
    {C_WREN, 8'h00, 8'd0,  8'h02, 4'd3},
    {C_WRSR, 8'h88, 8'd0,  8'h88, 4'd7},   // R7 level 3'b010, lock set
    {C_WREN, 8'h00, 8'd0,  8'h8A, 4'd3},
    {C_WRSR, 8'h1C, 8'd0,  8'h08, 4'd8},   // R8 level kept, lock cleared
    {C_WREN, 8'h00, 8'd0,  8'h0A, 4'd3},
    {C_WRSR, 8'h84, 8'd0,  8'h84, 4'd7},
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_WRSR, 8'h9C, 8'd0,  8'h84, 4'd8},   // R8 level kept, lock stays
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_PROG, 8'h00, 8'd0,  8'h87, 4'd5},   // R5 busy next clock
    {C_WREN, 8'h00, 8'd0,  8'h87, 4'd10},  // R10
    {C_WRDI, 8'h00, 8'd0,  8'h87, 4'd10},  // R10
    {C_WRSR, 8'h00, 8'd0,  8'h87, 4'd10},  // R10
    {C_SECT, 8'h00, 8'd0,  8'h87, 4'd10},  // R10
    {C_NONE, 8'h00, 8'd2,  8'h87, 4'd5},   // R5 last busy cycle of program
    {C_NONE, 8'h00, 8'd0,  8'h84, 4'd6},   // R6 latch falls with busy
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_SECT, 8'h00, 8'd0,  8'h87, 4'd5},
    {C_DONE, 8'h00, 8'd0,  8'h84, 4'd6},   // R6 early completion strobe
    {C_DONE, 8'h00, 8'd0,  8'h84, 4'd12},  // R12
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_BLK,  8'h00, 8'd0,  8'h87, 4'd5},
    {C_NONE, 8'h00, 8'd22, 8'h87, 4'd5},   // R5 last busy cycle of block erase
    {C_NONE, 8'h00, 8'd0,  8'h84, 4'd6},
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_CHIP, 8'h00, 8'd0,  8'h87, 4'd5},
    {C_NONE, 8'h00, 8'd38, 8'h87, 4'd5},   // R5 last busy cycle of chip erase
    {C_NONE, 8'h00, 8'd0,  8'h84, 4'd6},
    {C_WREN, 8'h00, 8'd0,  8'h86, 4'd3},
    {C_WRDI, 8'h00, 8'd0,  8'h84, 4'd3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
  logic [7:0] wrsr_data = '0;
  logic       cmd_prog = 0, cmd_sect_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
  logic       op_done = 0;
  logic [7:0] status_o;
  logic       busy_o, write_allowed_o, bp_lock_o;
  logic [2:0] bp_level_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_status_unit #(
    .USE_TIMER (1),
    .PROG_CYC  (PROG_CYC),
    .SECT_CYC  (SECT_CYC),
    .BLK_CYC   (BLK_CYC),
    .CHIP_CYC  (CHIP_CYC)
  ) dut_i (
    .clk             (clk),
    .rst             (rst),
    .cmd_wren        (cmd_wren),
    .cmd_wrdi        (cmd_wrdi),
    .cmd_wrsr        (cmd_wrsr),
    .wrsr_data       (wrsr_data),
    .cmd_prog        (cmd_prog),
    .cmd_sect_erase  (cmd_sect_erase),
    .cmd_blk_erase   (cmd_blk_erase),
    .cmd_chip_erase  (cmd_chip_erase),
    .op_done         (op_done),
    .status_o        (status_o),
    .busy_o          (busy_o),
    .write_allowed_o (write_allowed_o),
    .bp_level_o      (bp_level_o),
    .bp_lock_o       (bp_lock_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one strobe for one clock, driven and released on falling edges
  task automatic apply(input logic [3:0] cmd, input logic [7:0] data);
    wrsr_data      = data;
    cmd_wren       = (cmd == C_WREN);
    cmd_wrdi       = (cmd == C_WRDI);
    cmd_wrsr       = (cmd == C_WRSR);
    cmd_prog       = (cmd == C_PROG);
    cmd_sect_erase = (cmd == C_SECT);
    cmd_blk_erase  = (cmd == C_BLK);
    cmd_chip_erase = (cmd == C_CHIP);
    op_done        = (cmd == C_DONE);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_sect_erase,
     cmd_blk_erase, cmd_chip_erase, op_done} = '0;
  endtask

  // R11: derived outputs follow the status byte
  task automatic check_side(input logic [7:0] exp);
    check("R11 write_allowed", {7'd0, write_allowed_o}, {7'd0, exp[1] & ~exp[0]});
    check("R11 bp_level", {5'd0, bp_level_o}, {5'd0, exp[4:2]});
    check("R11 bp_lock", {7'd0, bp_lock_o}, {7'd0, exp[7]});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 reset value, R1 layout
    check("R2 reset status", status_o, 8'h1C);
    check("R2 reset busy", {7'd0, busy_o}, 8'h00);
    check_side(8'h1C);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VECS[i];
      apply(v[31:28], v[27:20]);
      repeat (int'(v[19:12])) @(negedge clk);
      check($sformatf("R%0d vector %0d", v[3:0], i), status_o, v[11:4]);
      check_side(v[11:4]);
    end

    // R2 reset in the middle of an internal write
    apply(C_WREN, 8'h00);
    apply(C_CHIP, 8'h00);
    check("R5 chip start", status_o, 8'h87);
    repeat (3) @(negedge clk);
    do_reset();
    check("R2 reset while busy", status_o, 8'h1C);
    check_side(8'h1C);

    // R12 completion strobe after reset, idle
    apply(C_DONE, 8'h00);
    check("R12 idle done", status_o, 8'h1C);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule